// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple synchronous request port and an external asynchronous static RAM. The RAM holds 524,288 bytes, so it needs a 19-bit address and an 8-bit data lane. A user issues one single-byte read or write at a time with `req`, `we`, `addr` and `wdata`. The controller then generates the active-low chip-enable, write-enable and output-enable strobes for the memory. For a read it returns the byte on `rdata`, and for either direction it raises `done` for one clock.

Every strobe edge falls on a system clock edge. Each timing window is a parameter in nanoseconds. The controller converts it to a clock count, rounding up against `CLK_PERIOD_NS`. A write pulls chip enable and write enable low with output enable held high. It then waits out the memory's write-enable-to-high-impedance time before it drives the data lane. The data stays stable until write enable rises. A read holds chip enable and output enable low with write enable high for the full access time. It samples the lane on the last clock of that window. Between accesses the chip is deselected, the lane is released and the address bus keeps its last value.

The memory lane is split into a `memDout`/`memDoutEn` pair toward the pad and a `memDin` input from it. Requests are accepted only while `ready` is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset `memCeN`, `memWeN` and `memOeN` are 1, `memDoutEn` is 0, `ready` is 1 and `done` is 0.
- R2: In a write, `memWeN` stays low for at least max(60 ns, 80 ns) rounded up to clocks (8 clocks at 10 ns). `memAddr` does not change while `memCeN` is low.
- R3: In a write, `memDoutEn` stays 0 for the first ceil(30 ns / period) clocks after `memWeN` falls (3 at 10 ns). `memDout` is then driven and stable for at least ceil(40 ns / period) clocks (4) before `memWeN` rises.
- R4: `memOeN` is 1 whenever `memWeN` is 0. A read holds `memCeN`=0, `memOeN`=0, `memWeN`=1 and `memDoutEn`=0.
- R5: A read samples `memDin` on the last clock of a window of ceil(100 ns / period) clocks (10) with a stable address. `rdata` then holds the byte most recently written to that address.
- R6: `done` is high for exactly one clock per access. `ready` is 0 from the accept edge until the edge that raises `done`. A `req` seen while `ready` is 0 is ignored.
- R7: Address changes on `memAddr` from consecutive accesses are at least ceil(100 ns / period) clocks apart.
- R8: When idle, all three strobes are 1, `memDoutEn` is 0 and `memAddr` keeps the last access address.
- R9: `done` rises 10 clocks after the accept edge for both reads and writes with default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled when ready is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write byte |
| ready | output | 1 | Controller idle, can accept a request |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-clock completion pulse |
| memAddr | output | 19 | Memory address bus |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDout | output | 8 | Byte driven toward the data lane |
| memDoutEn | output | 1 | Drive enable for memDout |
| memDin | input | 8 | Byte received from the data lane |

## Verification
A behavioural memory model returns an inverted, wrong byte until the read address has been stable for about a full access window. An early sample therefore shows up as a data mismatch. Directed writes and readbacks at the lowest and highest address, with all-zero and all-one data, tell apart address and data bit faults. Random mixed reads and writes over a small address pool, issued back to back, separate errors in ordering and turnaround from errors in timing. A request pulsed while busy shows whether the handshake really holds requests off. The model's width, setup and contention checks pin each strobe edge to its clock.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef struct packed {
    logic load;
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;
    logic capture;
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_async_control.sv
module sram_async_control
  import sram_async_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CYCLE_NS    = 100,
  parameter int T_WE_PULSE_NS = 60,
  parameter int T_ADDR_WE_NS  = 80,
  parameter int T_DSETUP_NS   = 40,
  parameter int T_WE_HIZ_NS   = 30,
  parameter int T_WE_GAP_NS   = 5,
  parameter int T_ACCESS_NS   = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    we,
  output logic    ready,
  output logic    done,
  output strobe_t strb
);

  localparam int NHIZ   = ceilDiv(T_WE_HIZ_NS, CLK_PERIOD_NS);
  localparam int NDS    = maxOf(ceilDiv(T_DSETUP_NS, CLK_PERIOD_NS), 1);
  localparam int NCYC   = ceilDiv(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int NWEL   = maxOf(maxOf(ceilDiv(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                      ceilDiv(T_ADDR_WE_NS, CLK_PERIOD_NS)),
                                NHIZ + NDS);
  localparam int NGAP   = maxOf(ceilDiv(T_WE_GAP_NS, CLK_PERIOD_NS), 1);
  localparam int NREC   = maxOf(NCYC - NWEL, NGAP);
  localparam int NRD    = maxOf(ceilDiv(T_ACCESS_NS, CLK_PERIOD_NS), NCYC);
  localparam int NMAX   = maxOf(maxOf(NWEL, NREC), NRD);
  localparam int CW     = $clog2(NMAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_HIZ, ST_WR_DRV, ST_WR_REC, ST_RD
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          cntZero;

  assign cntZero = (cnt == '0);
  assign ready   = (state == ST_IDLE);

  always_comb begin
    strb         = '0;
    strb.load    = (state == ST_IDLE) && req;
    strb.ceN     = !((state == ST_WR_HIZ) || (state == ST_WR_DRV) || (state == ST_RD));
    strb.weN     = !((state == ST_WR_HIZ) || (state == ST_WR_DRV));
    strb.oeN     = (state != ST_RD);
    strb.drive   = (state == ST_WR_DRV);
    strb.capture = (state == ST_RD) && cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            if (!we) begin
              state <= ST_RD;
              cnt   <= CW'(NRD - 1);
            end else if (NHIZ > 0) begin
              state <= ST_WR_HIZ;
              cnt   <= CW'(NHIZ - 1);
            end else begin
              state <= ST_WR_DRV;
              cnt   <= CW'(NWEL - 1);
            end
          end
        end
        ST_WR_HIZ: begin
          if (cntZero) begin
            state <= ST_WR_DRV;
            cnt   <= CW'(NWEL - NHIZ - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_DRV: begin
          if (cntZero) begin
            state <= ST_WR_REC;
            cnt   <= CW'(NREC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_REC: begin
          if (cntZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_RD: begin
          if (cntZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent run-length of the write-enable low phase
  logic [CW:0] weRun;
  always_ff @(posedge clk) begin
    if (!rstN) weRun <= '0;
    else if (!strb.weN) weRun <= weRun + 1'b1;
    else weRun <= '0;
  end

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.weN) |-> ($past(weRun) >= (CW+1)'(NWEL - 1)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(req));

endmodule

// File: rtl/sram_async_datapath.sv
module sram_async_datapath
  import sram_async_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= addr;
        wdataQ <= wdata;
      end
      if (strb.capture) rdataQ <= memDin;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign memDoutEn = strb.drive;
  assign memCeN    = strb.ceN;
  assign memWeN    = strb.weN;
  assign memOeN    = strb.oeN;
  assign rdata     = rdataQ;

  assert_drive_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memDoutEn && $past(memDoutEn)) |-> $stable(memDout));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  assert_oe_in_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  assert_no_drive_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDoutEn);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_async_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CYCLE_NS    = 100,
  parameter int T_WE_PULSE_NS = 60,
  parameter int T_ADDR_WE_NS  = 80,
  parameter int T_DSETUP_NS   = 40,
  parameter int T_WE_HIZ_NS   = 30,
  parameter int T_WE_GAP_NS   = 5,
  parameter int T_ACCESS_NS   = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  strobe_t strb;

  sram_async_control #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_CYCLE_NS(T_CYCLE_NS),
    .T_WE_PULSE_NS(T_WE_PULSE_NS), .T_ADDR_WE_NS(T_ADDR_WE_NS),
    .T_DSETUP_NS(T_DSETUP_NS), .T_WE_HIZ_NS(T_WE_HIZ_NS),
    .T_WE_GAP_NS(T_WE_GAP_NS), .T_ACCESS_NS(T_ACCESS_NS)
  ) control_i (
    .clk(clk), .rstN(rstN), .req(req), .we(we),
    .ready(ready), .done(done), .strb(strb)
  );

  sram_async_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wdata(wdata),
    .rdata(rdata), .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, done, memCeN, memWeN, memOeN, memDoutEn;
  logic [7:0]  rdata, memDout, memDin;
  logic [18:0] memAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .done(done), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0]  modelMem [int];
  logic [7:0]  refMem   [int];
  logic [7:0]  memQ = 8'h00;
  bit          prevRc = 0, prevWl = 0, prevDrv = 0, addrMoved = 0, seenAddr = 0;
  logic [18:0] prevAddr = '0;
  logic [7:0]  prevDout = '0;
  int          rdCnt = 0, weLow = 0, dsCnt = 0, sinceAddr = 0;

  function automatic logic [7:0] memRead(input logic [18:0] a);
    return modelMem.exists(int'(a)) ? modelMem[int'(a)] : 8'h00;
  endfunction

  assign memDin = memQ;

  always @(negedge clk) begin
    if (rstN) begin
      bit rc, wl;
      rc = !memCeN && memWeN && !memOeN;
      wl = !memCeN && !memWeN;
      if (rc && prevRc && memAddr == prevAddr) rdCnt++; else rdCnt = 0;
      // valid only after ~a full access window, otherwise a wrong byte
      memQ = (rc && rdCnt >= 9) ? memRead(memAddr) : ~memRead(memAddr);
      if (memDoutEn && rc) check(0, "R4 contention", 1, 0);
      if (wl) begin
        weLow++;
        if (prevWl && memAddr != prevAddr) addrMoved = 1;
      end
      if (memDoutEn) begin
        if (weLow <= 3) check(0, "R3 drive before hiZ", weLow, 4);
        if (prevDrv && memDout == prevDout) dsCnt++; else dsCnt = 1;
      end
      if (prevWl && !wl) begin
        check(weLow >= 8, "R2 we low width", weLow, 8);
        check(!addrMoved, "R2 addr stable", addrMoved, 0);
        check(prevDrv && dsCnt >= 4, "R3 data setup", dsCnt, 4);
        modelMem[int'(prevAddr)] = prevDout;
        weLow = 0; addrMoved = 0;
      end
      if (memAddr != prevAddr) begin
        if (seenAddr) check(sinceAddr >= 10, "R7 cycle time", sinceAddr, 10);
        seenAddr = 1; sinceAddr = 1;
      end else sinceAddr++;
      prevRc = rc; prevWl = wl; prevDrv = memDoutEn;
      prevAddr = memAddr; prevDout = memDout;
    end
  end

  // ---------------- access task ----------------
  task automatic access(input bit isWr, input logic [18:0] a, input logic [7:0] d);
    int lat;
    @(negedge clk);
    check(ready, "R6 ready before req", ready, 1);
    req = 1; we = isWr; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = $urandom_range(1); addr = $urandom; wdata = $urandom;
    check(!ready, "R6 busy after accept", ready, 0);
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      if (!done) lat++;
    end
    check(lat == 10, "R9 latency", lat, 10);
    if (isWr) refMem[int'(a)] = d;
    else begin
      logic [7:0] exp;
      exp = refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00;
      check(rdata == exp, "R5 readback", rdata, exp);
    end
    check(ready, "R6 ready with done", ready, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(memCeN && memWeN && memOeN, "R1 strobes", {memCeN, memWeN, memOeN}, 7);
    check(!memDoutEn, "R1 lane released", memDoutEn, 0);
    check(ready && !done, "R1 ready", {ready, done}, 2);

    // directed corners: extreme addresses and data
    access(1, 19'h7FFFF, 8'hFF);
    access(1, 19'h00000, 8'h00);
    access(0, 19'h7FFFF, 8'hFF);
    access(0, 19'h00000, 8'hFF);
    access(1, 19'h2AAAA, 8'h5A);
    access(0, 19'h2AAAA, 8'h5A);

    // R8: idle state keeps address
    repeat (3) @(negedge clk);
    check(memAddr == 19'h2AAAA, "R8 addr held", memAddr, 19'h2AAAA);
    check(memCeN && memWeN && memOeN && !memDoutEn, "R8 idle strobes",
          {memCeN, memWeN, memOeN, memDoutEn}, 14);

    // R6: done is a single pulse
    access(0, 19'h00000, 8'h00);
    @(negedge clk);
    check(!done, "R6 done one clock", done, 0);

    // R6: request during busy is ignored
    @(negedge clk);
    req = 1; we = 1; addr = 19'h01234; wdata = 8'h77;
    @(negedge clk);
    req = 0;
    refMem[int'(19'h01234)] = 8'h77;
    repeat (4) @(negedge clk);
    req = 1; we = 1; addr = 19'h01234; wdata = 8'h99;
    repeat (3) @(negedge clk);
    req = 0;
    begin
      int pulses;
      pulses = 0;
      repeat (20) begin
        @(negedge clk);
        if (done) pulses++;
      end
      check(pulses == 1, "R6 busy req ignored", pulses, 1);
    end
    access(0, 19'h01234, 8'h00);

    // random mixed back-to-back traffic over a small pool
    for (int i = 0; i < 80; i++) begin
      logic [18:0] a;
      a = {$urandom_range(15), 15'h1555} ^ 19'($urandom_range(3));
      access($urandom_range(1), a, 8'($urandom));
    end

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule